// File: doc/BRIEF.md
# Microcoded Instruction Sequencer

This block is the control unit for a small single-bus datapath. It holds the routine being executed, a micro-step counter and a computed control store. Every clock it emits one control word, whose strobes tell the datapath which register drives the shared bus, which registers capture it, and which arithmetic or overflow action takes place. Each routine ends by fetching the next opcode itself. Its final word is a micro-reset, which loads the next routine and restarts the step count.

The next opcode normally comes from the datapath's prefetch register. After a jump has been taken, it is taken instead from the memory word at the new program counter. The conditional jump opcode has two routines, and the overflow flag picks one of them at the micro-reset that loads it. The taken routine moves B into the PC and clears overflow. The not-taken routine fetches the next opcode and sets overflow.

Top module: `useq_top`

## Requirements
- R1: Opcodes are ADD=0, JOTO=1, LIT=2, LOAD=3, STOR=4, SWAP=5, SWPI=6, INC=7, NOP=8. While `rst_n` is low at a clock edge, the block enters the NOP routine at step 0, so `ctrl` shows the NOP first word (bits 1 and 18).
- R2: The step advances by one per clock. A word with bit 0 (micro-reset) set carries no other bit. At the next edge that word restarts the step at 0 and loads the next routine.
- R3: The fetch tail is four words: bit 1 (PC increment), then bit 2 (PC to bus), then bits 4 and 6 (memory to bus, next-opcode load), then bit 0.
- R4: ADD is bits 7+14+18, then 9+15, then 17+8, then the fetch tail. INC is the same except that its second word is bit 16 alone.
- R5: SWAP is 14+7, then 8+9, then 10+13, then the tail. SWPI is 14+9, then 10+11, then 12+13, then the tail.
- R6: LIT is 1, then 2, then 4+10, then the tail. LOAD is 11, then 4+10, then the tail. STOR is 11, then 5+9, then the tail.
- R7: NOP is the fetch tail with bit 18 added to its first word. Opcodes 9 to 15 run the NOP routine.
- R8: JOTO with `ovf` high at the loading micro-reset runs 9+3, then 18, then 0. With `ovf` low it runs the fetch tail with bit 19 added to its memory-read word.
- R9: If `jump_taken` has pulsed since the last micro-reset, the next routine is chosen from `mem_op` rather than `next_op`. This pending state clears at that micro-reset.
- R10: No control word drives more than one of the bus sources (bits 2, 4, 7, 9, 11, 13, 17).
- R11: Taking `rst_n` low in the middle of a routine abandons it. After the reset is released the block restarts in the NOP routine at step 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ovf | input | 1 | Datapath overflow flag |
| next_op | input | OP_W (4) | Prefetched next opcode |
| mem_op | input | OP_W (4) | Memory word at the current PC, opcode bits |
| jump_taken | input | 1 | Pulse: a jump has loaded the PC |
| ctrl | output | 20 | Control word for this cycle |

## Verification
A wrong routine register shows up at the first step of the next routine: one cycle after the micro-reset, the first word belongs to the wrong opcode. A corrupt step counter shows up at once as a word out of order. It can also show up as a tail that never reaches its micro-reset, or that reaches it too early, within at most seven cycles. A stale pending-jump state takes effect only at the following micro-reset, when the opcode source is wrong. For that reason the bench changes `next_op` and `mem_op` to opcodes with different first words on the two routines after a jump.

// File: rtl/useq_pkg.sv
// Shared constants for the microcoded sequencer: control-word bit
// positions, opcode values and routine identifiers.
// Assumes opcodes fit in four bits.
package useq_pkg;
    localparam int CW_W     = 20;
    localparam int CB_UR    = 0;   // micro-reset
    localparam int CB_PCINC = 1;
    localparam int CB_PCOUT = 2;
    localparam int CB_PCWR  = 3;
    localparam int CB_MOUT  = 4;
    localparam int CB_MWR   = 5;
    localparam int CB_NXWR  = 6;   // next-opcode register load
    localparam int CB_AOUT  = 7;
    localparam int CB_AWR   = 8;
    localparam int CB_BOUT  = 9;
    localparam int CB_BWR   = 10;
    localparam int CB_IOUT  = 11;
    localparam int CB_IWR   = 12;
    localparam int CB_LOUT  = 13;  // ALU latch to bus
    localparam int CB_LWR   = 14;  // ALU latch load
    localparam int CB_ADD   = 15;
    localparam int CB_INC   = 16;
    localparam int CB_ROUT  = 17;  // ALU result to bus
    localparam int CB_OCLR  = 18;
    localparam int CB_OSET  = 19;

    localparam int OPV_JOTO = 1;
    localparam int OPV_NOP  = 8;

    typedef enum logic [3:0] {
        RT_ADD  = 4'd0,
        RT_JNT  = 4'd1,   // jump, overflow clear
        RT_LIT  = 4'd2,
        RT_LOAD = 4'd3,
        RT_STOR = 4'd4,
        RT_SWAP = 4'd5,
        RT_SWPI = 4'd6,
        RT_INC  = 4'd7,
        RT_NOP  = 4'd8,
        RT_JT   = 4'd9    // jump, overflow set
    } rt_e;

    function automatic logic [CW_W-1:0] cb(input int n);
        return CW_W'(1) << n;
    endfunction
endpackage

// File: rtl/useq_fetch_sel.sv
// Chooses and holds the current routine. At a micro-reset it loads the
// routine for the next opcode. That opcode is taken from memory when a
// jump is pending and from the prefetch register otherwise. The overflow
// flag picks the jump variant.
// Assumes jump_taken is a pulse that arrives before the routine's micro-reset.
module useq_fetch_sel
    import useq_pkg::*;
#(
    parameter int OP_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ur,
    input  logic            ovf,
    input  logic            jump_taken,
    input  logic [OP_W-1:0] next_op,
    input  logic [OP_W-1:0] mem_op,
    output rt_e             rt
);
    logic            jmp_pend;
    logic [OP_W-1:0] op_src;
    rt_e             rt_nxt;

    // Pick the opcode source.
    always_comb op_src = (jmp_pend || jump_taken) ? mem_op : next_op;

    // Map the opcode to a routine, with unused codes falling to NOP.
    always_comb begin
        if (op_src > OP_W'(OPV_NOP))
            rt_nxt = RT_NOP;
        else if (op_src == OP_W'(OPV_JOTO))
            rt_nxt = ovf ? RT_JT : RT_JNT;
        else
            rt_nxt = rt_e'(op_src[3:0]);
    end

    // Hold the routine and the pending-jump state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rt       <= RT_NOP;
            jmp_pend <= 1'b0;
        end else begin
            if (ur) rt <= rt_nxt;
            if (ur) jmp_pend <= 1'b0;
            else if (jump_taken) jmp_pend <= 1'b1;
        end
    end

    assert_pend_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ur |=> !jmp_pend);
    assert_pend_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ur && jump_taken) |=> jmp_pend);
    assert_rt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ur |=> $stable(rt));
endmodule

// File: rtl/useq_step_ctr.sv
// Micro-step counter: counts up by one each clock and returns to zero
// after a micro-reset word.
// Assumes every routine is shorter than 2**STEP_W steps.
module useq_step_ctr #(
    parameter int STEP_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ur,
    output logic [STEP_W-1:0] step
);
    localparam logic [STEP_W-1:0] STEP_MAX = {STEP_W{1'b1}};

    // Advance the step, or restart it on micro-reset.
    always_ff @(posedge clk) begin
        if (!rst_n || ur) step <= '0;
        else              step <= step + 1'b1;
    end

    assert_step_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ur |=> step == '0);
    assert_step_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ur |=> step == STEP_W'($past(step) + 1'b1));
    assert_no_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        step == STEP_MAX |-> ur);
endmodule

// File: rtl/useq_ucode_rom.sv
// Computed control store. Each routine is a short prefix followed by the
// common fetch tail. NOP and the not-taken jump modify a word of the tail,
// and the taken jump has no tail. A step past the end yields a micro-reset.
// Assumes prefixes are at most three words long.
module useq_ucode_rom
    import useq_pkg::*;
#(
    parameter int STEP_W = 3
) (
    input  rt_e               rt,
    input  logic [STEP_W-1:0] step,
    output logic [CW_W-1:0]   cw
);
    localparam int PRE_N = 3;

    logic [CW_W-1:0]   pre [PRE_N];
    logic [STEP_W-1:0] plen;
    logic [STEP_W-1:0] ti;
    logic              no_tail;
    logic [CW_W-1:0]   tail_x0;
    logic [CW_W-1:0]   tail_x2;

    // Select the prefix words and tail modifiers for the routine.
    always_comb begin
        for (int k = 0; k < PRE_N; k++) pre[k] = '0;
        plen    = '0;
        no_tail = 1'b0;
        tail_x0 = '0;
        tail_x2 = '0;
        case (rt)
            RT_ADD, RT_INC: begin
                plen   = STEP_W'(3);
                pre[0] = cb(CB_AOUT) | cb(CB_LWR) | cb(CB_OCLR);
                pre[1] = (rt == RT_ADD) ? (cb(CB_BOUT) | cb(CB_ADD)) : cb(CB_INC);
                pre[2] = cb(CB_ROUT) | cb(CB_AWR);
            end
            RT_LIT: begin
                plen   = STEP_W'(3);
                pre[0] = cb(CB_PCINC);
                pre[1] = cb(CB_PCOUT);
                pre[2] = cb(CB_MOUT) | cb(CB_BWR);
            end
            RT_LOAD: begin
                plen   = STEP_W'(2);
                pre[0] = cb(CB_IOUT);
                pre[1] = cb(CB_MOUT) | cb(CB_BWR);
            end
            RT_STOR: begin
                plen   = STEP_W'(2);
                pre[0] = cb(CB_IOUT);
                pre[1] = cb(CB_MWR) | cb(CB_BOUT);
            end
            RT_SWAP: begin
                plen   = STEP_W'(3);
                pre[0] = cb(CB_LWR) | cb(CB_AOUT);
                pre[1] = cb(CB_AWR) | cb(CB_BOUT);
                pre[2] = cb(CB_BWR) | cb(CB_LOUT);
            end
            RT_SWPI: begin
                plen   = STEP_W'(3);
                pre[0] = cb(CB_LWR) | cb(CB_BOUT);
                pre[1] = cb(CB_BWR) | cb(CB_IOUT);
                pre[2] = cb(CB_IWR) | cb(CB_LOUT);
            end
            RT_JT: begin
                plen    = STEP_W'(3);
                no_tail = 1'b1;
                pre[0]  = cb(CB_BOUT) | cb(CB_PCWR);
                pre[1]  = cb(CB_OCLR);
                pre[2]  = cb(CB_UR);
            end
            RT_JNT:  tail_x2 = cb(CB_OSET);
            default: tail_x0 = cb(CB_OCLR);   // NOP
        endcase
    end

    // Produce the word for this step from the prefix or the fetch tail.
    always_comb begin
        ti = step - plen;
        if (step < plen)
            cw = pre[step[1:0]];
        else if (no_tail)
            cw = cb(CB_UR);
        else begin
            case (ti)
                STEP_W'(0): cw = cb(CB_PCINC) | tail_x0;
                STEP_W'(1): cw = cb(CB_PCOUT);
                STEP_W'(2): cw = cb(CB_MOUT) | cb(CB_NXWR) | tail_x2;
                default:    cw = cb(CB_UR);
            endcase
        end
    end
endmodule

// File: rtl/useq_top.sv
// Microcoded instruction sequencer top. It ties together the routine
// selector, the step counter and the control store, and drives one
// control word per clock to a single-bus datapath.
// Assumes the datapath acts on the strobes in the same cycle.
module useq_top
    import useq_pkg::*;
#(
    parameter int OP_W   = 4,
    parameter int STEP_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ovf,
    input  logic [OP_W-1:0] next_op,
    input  logic [OP_W-1:0] mem_op,
    input  logic            jump_taken,
    output logic [CW_W-1:0] ctrl
);
    rt_e               rt;
    logic [STEP_W-1:0] step;
    logic [CW_W-1:0]   cw;
    logic [6:0]        bus_src;

    useq_fetch_sel #(.OP_W(OP_W)) u_sel (
        .clk(clk), .rst_n(rst_n), .ur(cw[CB_UR]), .ovf(ovf),
        .jump_taken(jump_taken), .next_op(next_op), .mem_op(mem_op), .rt(rt)
    );

    useq_step_ctr #(.STEP_W(STEP_W)) u_step (
        .clk(clk), .rst_n(rst_n), .ur(cw[CB_UR]), .step(step)
    );

    useq_ucode_rom #(.STEP_W(STEP_W)) u_rom (
        .rt(rt), .step(step), .cw(cw)
    );

    // Drive the control word out.
    always_comb ctrl = cw;

    // Gather the bus-source strobes for checking.
    always_comb bus_src = {ctrl[CB_PCOUT], ctrl[CB_MOUT], ctrl[CB_AOUT], ctrl[CB_BOUT],
                           ctrl[CB_IOUT], ctrl[CB_LOUT], ctrl[CB_ROUT]};

    assert_one_driver_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bus_src));
    assert_ur_alone_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl[CB_UR] |-> $countones(ctrl) == 1);
    assert_ov_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctrl[CB_OSET] && ctrl[CB_OCLR]));
    assert_nop_after_reset_R1: assert property (@(posedge clk)
        !rst_n |=> ctrl == (cb(CB_PCINC) | cb(CB_OCLR)));
endmodule

// File: tb/useq_top_test.sv
`timescale 1ns/1ps
module useq_top_test;
    localparam logic [19:0] UR = 20'h1 << 0,  PI = 20'h1 << 1,  PO = 20'h1 << 2,
                            PW = 20'h1 << 3,  MO = 20'h1 << 4,  MW = 20'h1 << 5,
                            NW = 20'h1 << 6,  AO = 20'h1 << 7,  AW = 20'h1 << 8,
                            BO = 20'h1 << 9,  BW = 20'h1 << 10, IO = 20'h1 << 11,
                            IW = 20'h1 << 12, LO = 20'h1 << 13, LW = 20'h1 << 14,
                            AD = 20'h1 << 15, IN = 20'h1 << 16, RO = 20'h1 << 17,
                            OC = 20'h1 << 18, OS = 20'h1 << 19;
    localparam logic [19:0] BUSM = PO | MO | AO | BO | IO | LO | RO;

    typedef struct packed {
        logic [3:0]        op;
        logic              ov;
        logic [3:0]        req;
        logic [2:0]        len;
        logic [0:6][19:0]  w;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{op:4'd8,  ov:1'b0, req:4'd7, len:3'd4, w:'{PI|OC, PO, MO|NW, UR, 0, 0, 0}},          // R7 after reset
        '{op:4'd0,  ov:1'b0, req:4'd4, len:3'd7, w:'{AO|LW|OC, BO|AD, RO|AW, PI, PO, MO|NW, UR}}, // R4 ADD
        '{op:4'd7,  ov:1'b0, req:4'd4, len:3'd7, w:'{AO|LW|OC, IN, RO|AW, PI, PO, MO|NW, UR}},    // R4 INC
        '{op:4'd2,  ov:1'b0, req:4'd6, len:3'd7, w:'{PI, PO, MO|BW, PI, PO, MO|NW, UR}},          // R6 LIT
        '{op:4'd3,  ov:1'b0, req:4'd6, len:3'd6, w:'{IO, MO|BW, PI, PO, MO|NW, UR, 0}},           // R6 LOAD
        '{op:4'd4,  ov:1'b0, req:4'd6, len:3'd6, w:'{IO, MW|BO, PI, PO, MO|NW, UR, 0}},           // R6 STOR
        '{op:4'd5,  ov:1'b0, req:4'd5, len:3'd7, w:'{LW|AO, AW|BO, BW|LO, PI, PO, MO|NW, UR}},    // R5 SWAP
        '{op:4'd6,  ov:1'b0, req:4'd5, len:3'd7, w:'{LW|BO, BW|IO, IW|LO, PI, PO, MO|NW, UR}},    // R5 SWPI
        '{op:4'd1,  ov:1'b0, req:4'd8, len:3'd4, w:'{PI, PO, MO|NW|OS, UR, 0, 0, 0}},             // R8 not taken
        '{op:4'd1,  ov:1'b1, req:4'd8, len:3'd3, w:'{BO|PW, OC, UR, 0, 0, 0, 0}},                 // R8 taken
        '{op:4'd12, ov:1'b0, req:4'd7, len:3'd4, w:'{PI|OC, PO, MO|NW, UR, 0, 0, 0}},             // R7 unused code
        '{op:4'd15, ov:1'b0, req:4'd7, len:3'd4, w:'{PI|OC, PO, MO|NW, UR, 0, 0, 0}},             // R7 unused code
        '{op:4'd9,  ov:1'b0, req:4'd7, len:3'd4, w:'{PI|OC, PO, MO|NW, UR, 0, 0, 0}}              // R7 unused code
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ovf = 1'b0;
    logic [3:0]  next_op = 4'd0;
    logic [3:0]  mem_op = 4'd0;
    logic        jump_taken = 1'b0;
    logic [19:0] ctrl;
    int          checks = 0;
    int          failures = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    useq_top uut (
        .clk(clk), .rst_n(rst_n), .ovf(ovf), .next_op(next_op),
        .mem_op(mem_op), .jump_taken(jump_taken), .ctrl(ctrl)
    );

    task automatic chk(input string req, input logic [19:0] act, input logic [19:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset word", ctrl, PI | OC);
        rst_n = 1'b1;
        for (int k = 0; k < NV; k++) begin
            for (int s = 0; s < int'(VEC[k].len); s++) begin
                if (s == int'(VEC[k].len) - 1)
                    chk($sformatf("R2 micro-reset row %0d", k), ctrl, VEC[k].w[s]);
                else if (s >= int'(VEC[k].len) - 4 && VEC[k].op != 4'd1 && k != 0 && VEC[k].req != 4'd7)
                    chk($sformatf("R3 fetch tail row %0d step %0d", k, s), ctrl, VEC[k].w[s]);
                else
                    chk($sformatf("R%0d row %0d step %0d", VEC[k].req, k, s), ctrl, VEC[k].w[s]);
                chk("R10 single bus driver", 20'($countones(ctrl & BUSM) <= 1), 20'd1);
                if (s == int'(VEC[k].len) - 1) begin
                    if (k + 1 < NV) begin
                        next_op = VEC[k + 1].op;
                        ovf     = VEC[k + 1].ov;
                    end else begin
                        next_op = 4'd1;
                        ovf     = 1'b1;
                    end
                end
                @(negedge clk);
            end
        end
        // R8 taken jump with a jump pulse for R9
        chk("R8 taken first word", ctrl, BO | PW);
        jump_taken = 1'b1;
        @(negedge clk);
        jump_taken = 1'b0;
        ovf = 1'b0;
        chk("R8 taken clears overflow", ctrl, OC);
        @(negedge clk);
        chk("R8 taken micro-reset", ctrl, UR);
        mem_op  = 4'd0;
        next_op = 4'd3;
        @(negedge clk);
        chk("R9 opcode taken from memory", ctrl, AO | LW | OC);
        repeat (6) @(negedge clk);
        chk("R2 ADD micro-reset", ctrl, UR);
        next_op = 4'd4;
        mem_op  = 4'd5;
        @(negedge clk);
        chk("R9 pending cleared, prefetch used", ctrl, IO);
        @(negedge clk);
        chk("R6 STOR second word", ctrl, MW | BO);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R11 reset mid-routine", ctrl, PI | OC);
        @(negedge clk);
        chk("R11 held in reset", ctrl, PI | OC);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 restart step 1", ctrl, PO);
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule